// File: doc/BRIEF.md
# Two-Wire Slave Bus Event Detector

This block watches the already-sampled clock and data lines of a two-wire serial bus on behalf of a slave interface. It finds bus start and stop conditions, collects the eight bits that follow each start, and compares the seven address bits in that frame with a configured slave address. The slave logic receives a one-cycle pulse for each of four events: a matched transaction opened by a fresh start, a matched repeated start for writing, a matched repeated start for reading, and the stop that closes a matched transaction.

A second function guards against a stalled bus. A transaction is active from a start condition until a stop, a mismatched address or a timeout. While it is active, the block counts consecutive clock cycles in which the bus clock is low. When that count reaches a programmable limit, it emits a timeout pulse and returns the detector to idle. The surrounding slave uses that pulse to reset itself. Data bytes after the address, acknowledge driving and buffering belong to other blocks.

Top module: `twi_event_detect`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, all five event outputs are low and the detector is idle. A stop on an idle bus then produces no event.
- R2: A start condition is SDA falling while SCL is high on both this sample and the previous one. A stop condition is SDA rising under the same SCL condition. After a start, the frame is taken from SDA on the next eight SCL rising edges, MSB first. Frame bits 7..1 are the address and frame bit 0 is the read/write bit, where 1 means read.
- R3: When a start is seen outside a matched transaction and the frame address equals `own_addr_i`, `evt_start_o` pulses for one cycle. The pulse comes in the clock cycle after the edge that samples the eighth rising SCL, and it does not depend on the read/write bit.
- R4: A start seen inside a matched transaction is a repeated start and never raises `evt_start_o`. If it is followed by a matching address with the read/write bit 0, `evt_rstrt_wr_o` pulses instead.
- R5: A repeated start followed by a matching address with the read/write bit 1 pulses `evt_rstrt_rd_o`.
- R6: A frame whose address differs from `own_addr_i` raises no event and returns the detector to idle. A later stop raises nothing, and the next start is treated as a fresh start.
- R7: `evt_stop_o` pulses only for a stop that ends a matched transaction. A stop in idle or during the address phase raises no event and returns the detector to idle.
- R8: While a transaction is active, SCL sampled low for `low_limit_i` consecutive cycles pulses `evt_timeout_o` in the cycle after the last of them and returns the detector to idle. Any sample with SCL high restarts the count.
- R9: A `low_limit_i` of zero disables the timeout entirely.
- R10: At most one event output is high in any cycle, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| own_addr_i | input | ADDR_W | Slave address to match |
| low_limit_i | input | CNT_W | Clock-low timeout limit in cycles, where 0 means off |
| evt_start_o | output | 1 | Matched transaction opened by a fresh start |
| evt_rstrt_wr_o | output | 1 | Matched repeated start, write direction |
| evt_rstrt_rd_o | output | 1 | Matched repeated start, read direction |
| evt_stop_o | output | 1 | Stop ending a matched transaction |
| evt_timeout_o | output | 1 | Clock held low too long, slave interface reset |

## Verification
The bench builds the block with a 7-bit address and a 6-bit limit counter, so every programmable limit can be reached within a short run. It uses limits of 12 for normal traffic, 5 to land low runs exactly one short of and exactly at the limit, and 0 for the disabled case, where the clock stays low for 80 cycles. Frames go to the configured address and to a neighbour address with one bit flipped. Repeated starts are placed both inside a matched transaction and in the middle of an address phase.

// File: rtl/twi_evt_pkg.sv
package twi_evt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_LIVE = 2'd2
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic low;
    } line_ev_t;

    typedef struct packed {
        logic start;
        logic rstrt_wr;
        logic rstrt_rd;
        logic stop;
        logic timeout;
    } evt_t;

    // Choose the event raised by a matched frame
    function automatic evt_t classify(input logic repeated, input logic rw);
        evt_t e;
        e = '0;
        if (!repeated)
            e.start = 1'b1;
        else if (rw)
            e.rstrt_rd = 1'b1;
        else
            e.rstrt_wr = 1'b1;
        return e;
    endfunction

endpackage

// File: rtl/twi_line_cond.sv
module twi_line_cond
    import twi_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.start = scl_q & scl_i & sda_q & ~sda_i;
        ev_o.stop  = scl_q & scl_i & ~sda_q & sda_i;
        ev_o.rise  = ~scl_q & scl_i;
        ev_o.low   = ~scl_i;
    end

endmodule

// File: rtl/twi_addr_shift.sv
module twi_addr_shift #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               shift_en,
    input  logic               bit_i,
    output logic               done_o,
    output logic [FRAME_W-1:0] frame_o
);

    localparam int CW = $clog2(FRAME_W);

    logic [FRAME_W-1:0] sh;
    logic [CW-1:0]      cnt;
    logic               last;

    assign last    = (cnt == CW'(FRAME_W - 1));
    assign done_o  = shift_en & last;
    assign frame_o = {sh[FRAME_W-2:0], bit_i};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh  <= '0;
            cnt <= '0;
        end else if (shift_en) begin
            sh  <= frame_o;
            cnt <= last ? '0 : cnt + CW'(1);
        end
    end

endmodule

// File: rtl/twi_low_watch.sv
module twi_low_watch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  logic             low,
    input  logic [CNT_W-1:0] limit_i,
    output logic             hit_o
);

    logic [CNT_W-1:0] run;

    assign hit_o = armed & low & (limit_i != '0) & (run == limit_i - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !armed || !low || hit_o)
            run <= '0;
        else
            run <= run + CNT_W'(1);
    end

    // R8: after a hit the run count starts over
    assert_run_restarts_R8: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> (run == '0));

endmodule

// File: rtl/twi_event_detect.sv
module twi_event_detect
    import twi_evt_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [CNT_W-1:0]  low_limit_i,
    output logic              evt_start_o,
    output logic              evt_rstrt_wr_o,
    output logic              evt_rstrt_rd_o,
    output logic              evt_stop_o,
    output logic              evt_timeout_o
);

    localparam int FRAME_W = ADDR_W + 1;

    line_ev_t           lev;
    logic               done;
    logic [FRAME_W-1:0] frame;
    logic               hit;
    phase_t             phase, phase_n;
    logic               repeated, repeated_n;
    evt_t               evt_q, evt_n;

    twi_line_cond u_line (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (lev)
    );

    twi_addr_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (lev.start),
        .shift_en ((phase == ST_ADDR) & lev.rise),
        .bit_i    (sda_i),
        .done_o   (done),
        .frame_o  (frame)
    );

    twi_low_watch #(.CNT_W(CNT_W)) u_watch (
        .clk     (clk),
        .rst     (rst),
        .armed   (phase != ST_IDLE),
        .low     (lev.low),
        .limit_i (low_limit_i),
        .hit_o   (hit)
    );

    always_comb begin
        phase_n    = phase;
        repeated_n = repeated;
        evt_n      = '0;
        if (hit) begin
            phase_n       = ST_IDLE;
            evt_n.timeout = 1'b1;
        end else if (lev.start) begin
            repeated_n = (phase == ST_LIVE);
            phase_n    = ST_ADDR;
        end else if (lev.stop) begin
            evt_n.stop = (phase == ST_LIVE);
            phase_n    = ST_IDLE;
        end else if (done) begin
            if (frame[FRAME_W-1:1] == own_addr_i) begin
                phase_n = ST_LIVE;
                evt_n   = classify(repeated, frame[0]);
            end else begin
                phase_n = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= ST_IDLE;
            repeated <= 1'b0;
            evt_q    <= '0;
        end else begin
            phase    <= phase_n;
            repeated <= repeated_n;
            evt_q    <= evt_n;
        end
    end

    assign evt_start_o    = evt_q.start;
    assign evt_rstrt_wr_o = evt_q.rstrt_wr;
    assign evt_rstrt_rd_o = evt_q.rstrt_rd;
    assign evt_stop_o     = evt_q.stop;
    assign evt_timeout_o  = evt_q.timeout;

    assert_one_event_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_start_o, evt_rstrt_wr_o, evt_rstrt_rd_o, evt_stop_o, evt_timeout_o}));

    assert_start_single_R10: assert property (@(posedge clk) disable iff (rst)
        evt_start_o |=> !evt_start_o);

    assert_start_enters_live_R3: assert property (@(posedge clk) disable iff (rst)
        evt_start_o |-> (phase == ST_LIVE) && !$past(repeated));

    assert_restart_from_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (evt_rstrt_wr_o || evt_rstrt_rd_o) |-> ($past(phase) == ST_ADDR) && $past(repeated));

    assert_stop_from_live_R7: assert property (@(posedge clk) disable iff (rst)
        evt_stop_o |-> (phase == ST_IDLE) && ($past(phase) == ST_LIVE));

    assert_timeout_low_R8: assert property (@(posedge clk) disable iff (rst)
        evt_timeout_o |-> ($past(scl_i) == 1'b0) && ($past(phase) != ST_IDLE) && (phase == ST_IDLE));

    assert_timeout_off_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(low_limit_i) == '0) |-> !evt_timeout_o);

endmodule

// File: tb/test_twi_event_detect.sv
module test_twi_event_detect;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic [6:0] own = 7'h2C;
    logic [5:0] limit = 6'd12;
    logic       e_start, e_wr, e_rd, e_stop, e_to;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int  m_state = 0;       // 0 idle, 1 collecting address, 2 matched
    bit  m_rep = 1'b0;
    bit  m_ps = 1'b1, m_pd = 1'b1;
    int  m_low = 0;
    bit  m_bits[$];
    bit  exp_ev[5];
    int  tally[5];
    int  base[5];

    always #10 clk = ~clk;

    twi_event_detect #(.ADDR_W(7), .CNT_W(6)) i_twi_event_detect (
        .clk            (clk),
        .rst            (rst),
        .scl_i          (scl),
        .sda_i          (sda),
        .own_addr_i     (own),
        .low_limit_i    (limit),
        .evt_start_o    (e_start),
        .evt_rstrt_wr_o (e_wr),
        .evt_rstrt_rd_o (e_rd),
        .evt_stop_o     (e_stop),
        .evt_timeout_o  (e_to)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic model_step(input bit s, input bit d);
        bit is_start, is_stop, is_rise;
        int v;
        is_start = m_ps && s && m_pd && !d;
        is_stop  = m_ps && s && !m_pd && d;
        is_rise  = !m_ps && s;
        for (int i = 0; i < 5; i++) exp_ev[i] = 1'b0;
        if (m_state != 0 && !s) begin
            m_low++;
            if (limit != 0 && m_low == int'(limit)) begin
                exp_ev[4] = 1'b1;
                m_state = 0;
                m_low = 0;
            end
        end else begin
            m_low = 0;
        end
        if (is_start) begin
            m_rep = (m_state == 2);
            m_state = 1;
            m_bits.delete();
        end else if (is_stop) begin
            if (m_state == 2) exp_ev[3] = 1'b1;
            m_state = 0;
        end else if (is_rise && m_state == 1) begin
            m_bits.push_back(d);
            if (m_bits.size() == 8) begin
                v = 0;
                for (int i = 0; i < 7; i++) v = v * 2 + int'(m_bits[i]);
                if (v == int'(own)) begin
                    m_state = 2;
                    if (!m_rep) exp_ev[0] = 1'b1;
                    else if (m_bits[7]) exp_ev[2] = 1'b1;
                    else exp_ev[1] = 1'b1;
                end else begin
                    m_state = 0;
                end
            end
        end
        m_ps = s;
        m_pd = d;
    endtask

    task automatic compare_all();
        bit got[5];
        string tags[5];
        got = '{e_start, e_wr, e_rd, e_stop, e_to};
        tags = '{"R3", "R4", "R5", "R7", "R8"};
        checks++;
        for (int i = 0; i < 5; i++) begin
            if (got[i]) tally[i]++;
            if (got[i] !== exp_ev[i]) begin
                errors++;
                $display("FAIL %s output %0d at %0t: actual %0b expected %0b",
                         tags[i], i, $time, got[i], exp_ev[i]);
            end
        end
    endtask

    task automatic step(input bit s, input bit d);
        scl = s;
        sda = d;
        @(posedge clk);
        model_step(s, d);
        #1;
        compare_all();
    endtask

    task automatic steps(input bit s, input bit d, input int n);
        for (int i = 0; i < n; i++) step(s, d);
    endtask

    task automatic bus_start();
        steps(1, 1, 2); steps(1, 0, 2); steps(0, 0, 2);
    endtask

    task automatic bus_restart();
        steps(0, 1, 2); steps(1, 1, 3); steps(1, 0, 2); steps(0, 0, 2);
    endtask

    task automatic bus_stop();
        steps(0, 0, 2); steps(1, 0, 3); steps(1, 1, 3);
    endtask

    task automatic send_bit(input bit b);
        steps(0, b, 2); steps(1, b, 3); steps(0, b, 1);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        send_bit(1'b0);
    endtask

    task automatic mark();
        for (int i = 0; i < 5; i++) base[i] = tally[i];
    endtask

    task automatic expect_counts(input string tag, input int s, input int w,
                                 input int r, input int p, input int t);
        int want[5];
        want = '{s, w, r, p, t};
        for (int i = 0; i < 5; i++) begin
            checks++;
            if (tally[i] - base[i] != want[i]) begin
                errors++;
                $display("FAIL %s pulse count %0d: actual %0d expected %0d",
                         tag, i, tally[i] - base[i], want[i]);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 5; i++) tally[i] = 0;
        repeat (4) @(posedge clk);
        #1;
        checks++;
        if ({e_start, e_wr, e_rd, e_stop, e_to} !== 5'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: actual %b expected 00000",
                     {e_start, e_wr, e_rd, e_stop, e_to});
        end
        rst = 1'b0;
        for (int i = 0; i < 5; i++) exp_ev[i] = 1'b0;
        compare_all();                       // R1 first cycle after release

        mark(); steps(1, 1, 3); bus_stop();
        expect_counts("R1", 0, 0, 0, 0, 0);  // R1 stop on idle bus

        // R3 R5 R7: start write, data, restart read, stop
        mark();
        bus_start(); send_byte({own, 1'b0}); send_byte(8'h55);
        bus_restart(); send_byte({own, 1'b1}); send_byte(8'hA3); bus_stop();
        expect_counts("R5", 1, 0, 1, 1, 0);

        // R4: restart with write
        mark();
        bus_start(); send_byte({own, 1'b1}); bus_restart(); send_byte({own, 1'b0}); bus_stop();
        expect_counts("R4", 1, 1, 0, 1, 0);

        // R6: mismatch, then stop, then fresh start
        mark();
        bus_start(); send_byte({own ^ 7'h01, 1'b1}); send_byte(8'h0F); bus_stop();
        expect_counts("R6", 0, 0, 0, 0, 0);
        mark();
        bus_start(); send_byte({own, 1'b1}); bus_stop();
        expect_counts("R6", 1, 0, 0, 1, 0);

        // R7: stop during address phase
        mark();
        bus_start(); send_bit(0); send_bit(1); send_bit(0); bus_stop();
        expect_counts("R7", 0, 0, 0, 0, 0);

        // R2: start inside address phase is a fresh start
        mark();
        bus_start(); send_bit(1); send_bit(1); send_bit(0);
        bus_restart(); send_byte({own, 1'b0}); bus_stop();
        expect_counts("R2", 1, 0, 0, 1, 0);

        // R8: timeout during address phase, stop afterwards is silent
        mark();
        bus_start(); send_bit(0); send_bit(1); steps(0, 0, 20); bus_stop();
        expect_counts("R8", 0, 0, 0, 0, 1);

        // R8: exact boundary with limit 5
        limit = 6'd5;
        mark();
        bus_start(); send_byte({own, 1'b0});
        steps(0, 0, 3); steps(1, 0, 2);      // run of 4, no timeout
        expect_counts("R8", 1, 0, 0, 0, 0);
        mark();
        steps(0, 0, 5); bus_stop();          // run of 5 hits
        expect_counts("R8", 0, 0, 0, 0, 1);

        // R9: limit zero disables timeout
        limit = 6'd0;
        mark();
        bus_start(); send_byte({own, 1'b1}); steps(0, 0, 80); bus_stop();
        expect_counts("R9", 1, 0, 0, 1, 0);

        // R10: different address, back-to-back restarts
        limit = 6'd12;
        own = 7'h51;
        mark();
        bus_start(); send_byte({own, 1'b0}); bus_restart(); send_byte({own, 1'b1});
        bus_restart(); send_byte({own, 1'b0}); bus_stop(); steps(1, 1, 4);
        expect_counts("R10", 1, 1, 1, 1, 0);

        finish_run();
    end

endmodule